// File: doc/BRIEF.md
# Variable-Page Translation Buffer

This block caches virtual-to-physical translations for a processor's load/store and fetch paths. Each slot holds one translation with its own page size, so 4 KB, 2 MB and 4 MB pages can sit side by side in the same small array. A page walker fills slots through the insert port. The lookup port takes a virtual address and returns, in the same cycle, whether it is covered by a slot, the physical address and the attribute bits of that slot.

A match is a range test. The address must lie at or above a slot's virtual base and below that base plus the slot's page size. It is not a fixed-width tag compare. Replacement follows true least-recently-used order. That order is kept as one age rank per slot. An insert makes the new entry the youngest. A lookup can refresh the order of the entry it hits, or leave the order alone, under the control of a per-request flag.

One cycle after a lookup, a registered hit flag and a registered translation-fault flag report its outcome. When paging is switched off, addresses pass through untranslated and no fault is raised.

Top module: `vpage_tlb`

## Requirements
- R1: After reset no slot is valid: a lookup with paging on misses, and `hitQ` and `faultQ` are 0.
- R2: A slot matches address A when its base B satisfies B <= A < B + S. S is set by the size code: 0 gives 4 KB, 1 gives 2 MB, 2 gives 4 MB, and 3 is treated as 4 KB. `lkHit` = `lkValid` AND `pagingOn` AND (any valid slot matches).
- R3: On insert, the stored virtual base and physical base both have their bits below the page size cleared.
- R4: On a hit, `lkPaddr` = physical base OR (A AND (S-1)), and `lkAttr` is the stored attribute word. Its bit order is: bit0 writable, bit1 user, bit2 no-execute, bit3 uncacheable, bit4 global, bit5 page-attribute-table select. When several slots match, the lowest-indexed slot supplies the result.
- R5: With `pagingOn` low, `lkPaddr` equals the zero-extended lookup address, `lkHit` and `lkAttr` are 0, no fault is raised and the age order is not changed.
- R6: One cycle after a lookup, `hitQ` equals the `lkHit` of that lookup. `faultQ` is 1 exactly when that lookup had `lkValid` and `pagingOn` set and missed. The two are never 1 together.
- R7: An insert takes the lowest-indexed never-used slot while one exists.
- R8: When all slots are in use, an insert replaces the least recently used slot, and the new entry becomes most recently used.
- R9: A hit with `lkTouch` = 1 makes the matched slot most recently used. A hit with `lkTouch` = 0 leaves the age order unchanged.
- R10: When an insert and a lookup fall in the same cycle, the lookup sees the contents from before the insert. The insert's aging is applied first and the lookup's touch second, so a touched entry ends up youngest and the new entry second youngest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insValid | input | 1 | Insert strobe from the page walker |
| insVaddr | input | VA_W | Virtual address of the new translation |
| insSize | input | 2 | Page size code (0: 4 KB, 1: 2 MB, 2: 4 MB, 3: 4 KB) |
| insPbase | input | PA_W | Physical frame address of the new translation |
| insAttr | input | 6 | Attribute word for the new translation |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | VA_W | Lookup virtual address |
| lkTouch | input | 1 | Refresh age order on hit |
| pagingOn | input | 1 | Paging enable; low means pass-through |
| lkHit | output | 1 | Combinational hit |
| lkPaddr | output | PA_W | Combinational physical address |
| lkAttr | output | 6 | Combinational attributes of the hit slot |
| hitQ | output | 1 | Registered hit of the previous cycle's lookup |
| faultQ | output | 1 | Registered translation fault of the previous cycle's lookup |

## Verification
The bench builds the block with four slots, a 32-bit virtual address and a 36-bit physical address. With only four slots, the array fills after a handful of inserts, so eviction, rank reshuffling and the same-cycle insert-plus-touch case come up again and again under random stimulus. The 32-bit virtual space is wide enough for several 4 MB pages to overlap 2 MB and 4 KB entries, so priority among multiple matches and the exact upper and lower page boundaries are exercised for every size code.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

  // Slot indices travel in a fixed-width field; NUM_SLOTS must not exceed 2**SLOT_IDX_W.
  localparam int SLOT_IDX_W = 8;
  localparam int ATTR_W     = 6;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_2M  = 2'd1,
    PG_4M  = 2'd2,
    PG_ALT = 2'd3
  } pgSize_e;

  typedef struct packed {
    logic pat;
    logic glob;
    logic uncache;
    logic noExec;
    logic user;
    logic writable;
  } attr_t;

  // Strobes from the aging control to the slot datapath.
  typedef struct packed {
    logic                  wrEn;
    logic [SLOT_IDX_W-1:0] wrSlot;
  } ctlStrobe_t;

  function automatic logic [4:0] pageShift(input logic [1:0] sz);
    case (sz)
      PG_2M:   return 5'd21;
      PG_4M:   return 5'd22;
      default: return 5'd12;
    endcase
  endfunction

endpackage

// File: rtl/vpt_datapath.sv
module vpt_datapath
  import vpt_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 36
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctlStrobe_t            strobe,
  input  logic [VA_W-1:0]       insVaddr,
  input  logic [1:0]            insSize,
  input  logic [PA_W-1:0]       insPbase,
  input  logic [ATTR_W-1:0]     insAttr,
  input  logic [VA_W-1:0]       lkVaddr,
  output logic [NUM_SLOTS-1:0]  validVec,
  output logic                  anyMatch,
  output logic [SLOT_IDX_W-1:0] hitSlot,
  output logic [PA_W-1:0]       matchPaddr,
  output logic [ATTR_W-1:0]     matchAttr
);

  logic              validQ [NUM_SLOTS];
  logic [VA_W-1:0]   vbaseQ [NUM_SLOTS];
  logic [1:0]        sizeQ  [NUM_SLOTS];
  logic [PA_W-1:0]   pbaseQ [NUM_SLOTS];
  logic [ATTR_W-1:0] attrQ  [NUM_SLOTS];
  logic [4:0]        shiftQ [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] matchVec;

  // Alignment of the incoming translation to its own page size.
  logic [4:0]      insShift;
  logic [VA_W-1:0] insVmask;
  logic [PA_W-1:0] insPmask;

  assign insShift = pageShift(insSize);
  assign insVmask = (VA_W'(1) << insShift) - VA_W'(1);
  assign insPmask = (PA_W'(1) << insShift) - PA_W'(1);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [VA_W:0] limit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        validQ[g] <= 1'b0;
        vbaseQ[g] <= '0;
        sizeQ[g]  <= '0;
        pbaseQ[g] <= '0;
        attrQ[g]  <= '0;
      end else if (strobe.wrEn && strobe.wrSlot == SLOT_IDX_W'(g)) begin
        validQ[g] <= 1'b1;
        vbaseQ[g] <= insVaddr & ~insVmask;
        sizeQ[g]  <= insSize;
        pbaseQ[g] <= insPbase & ~insPmask;
        attrQ[g]  <= insAttr;
      end
    end

    assign shiftQ[g]   = pageShift(sizeQ[g]);
    assign limit       = {1'b0, vbaseQ[g]} + ((VA_W+1)'(1) << shiftQ[g]);
    assign matchVec[g] = validQ[g] && (vbaseQ[g] <= lkVaddr) && ({1'b0, lkVaddr} < limit);
    assign validVec[g] = validQ[g];
  end

  // Lowest-indexed match wins: scan from the top so the lowest index is written last.
  logic [PA_W-1:0] selPbase;
  logic [4:0]      selShift;
  logic [VA_W-1:0] selVmask;

  always_comb begin
    anyMatch  = 1'b0;
    hitSlot   = '0;
    selPbase  = '0;
    selShift  = 5'd12;
    matchAttr = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        anyMatch  = 1'b1;
        hitSlot   = SLOT_IDX_W'(i);
        selPbase  = pbaseQ[i];
        selShift  = shiftQ[i];
        matchAttr = attrQ[i];
      end
    end
  end

  assign selVmask   = (VA_W'(1) << selShift) - VA_W'(1);
  assign matchPaddr = selPbase | PA_W'(lkVaddr & selVmask);

endmodule

// File: rtl/vpt_lru_ctrl.sv
module vpt_lru_ctrl
  import vpt_pkg::*;
#(
  parameter int NUM_SLOTS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  insValid,
  input  logic                  lkValid,
  input  logic                  lkTouch,
  input  logic                  pagingOn,
  input  logic                  anyMatch,
  input  logic [SLOT_IDX_W-1:0] hitSlot,
  input  logic [NUM_SLOTS-1:0]  validVec,
  output ctlStrobe_t            strobe,
  output logic                  hitQ,
  output logic                  faultQ
);

  localparam int IDXW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [IDXW-1:0] OLDEST = IDXW'(NUM_SLOTS - 1);

  // Age rank per slot: 0 is youngest, NUM_SLOTS-1 is oldest; always a permutation.
  logic [IDXW-1:0] rankQ [NUM_SLOTS];
  logic [IDXW-1:0] rankA [NUM_SLOTS];
  logic [IDXW-1:0] rankB [NUM_SLOTS];

  logic                  haveFree;
  logic [SLOT_IDX_W-1:0] victim;
  logic [IDXW-1:0]       insRank;
  logic [IDXW-1:0]       hitRank;
  logic                  lookActive;
  logic                  touchHit;

  assign lookActive = lkValid && pagingOn;
  assign touchHit   = lookActive && anyMatch && lkTouch;

  // Victim: lowest free slot, otherwise the oldest slot.
  always_comb begin
    haveFree = 1'b0;
    victim   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        haveFree = 1'b1;
        victim   = SLOT_IDX_W'(i);
      end
    end
    if (!haveFree) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (rankQ[i] == OLDEST) victim = SLOT_IDX_W'(i);
      end
    end
  end

  // Insert aging first, then the lookup touch on top of it.
  always_comb begin
    insRank = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (SLOT_IDX_W'(i) == victim) insRank = rankQ[i];
    end
    for (int i = 0; i < NUM_SLOTS; i++) begin
      rankA[i] = rankQ[i];
      if (insValid) begin
        if (SLOT_IDX_W'(i) == victim)  rankA[i] = '0;
        else if (rankQ[i] < insRank)   rankA[i] = rankQ[i] + IDXW'(1);
      end
    end
    hitRank = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (SLOT_IDX_W'(i) == hitSlot) hitRank = rankA[i];
    end
    for (int i = 0; i < NUM_SLOTS; i++) begin
      rankB[i] = rankA[i];
      if (touchHit) begin
        if (SLOT_IDX_W'(i) == hitSlot) rankB[i] = '0;
        else if (rankA[i] < hitRank)   rankB[i] = rankA[i] + IDXW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) rankQ[i] <= IDXW'(i);
      hitQ   <= 1'b0;
      faultQ <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) rankQ[i] <= rankB[i];
      hitQ   <= lookActive && anyMatch;
      faultQ <= lookActive && !anyMatch;
    end
  end

  assign strobe.wrEn   = insValid;
  assign strobe.wrSlot = victim;

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import vpt_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insValid,
  input  logic [VA_W-1:0]   insVaddr,
  input  logic [1:0]        insSize,
  input  logic [PA_W-1:0]   insPbase,
  input  logic [5:0]        insAttr,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic              lkTouch,
  input  logic              pagingOn,
  output logic              lkHit,
  output logic [PA_W-1:0]   lkPaddr,
  output logic [5:0]        lkAttr,
  output logic              hitQ,
  output logic              faultQ
);

  ctlStrobe_t            strobe;
  logic [NUM_SLOTS-1:0]  validVec;
  logic                  anyMatch;
  logic [SLOT_IDX_W-1:0] hitSlot;
  logic [PA_W-1:0]       matchPaddr;
  logic [ATTR_W-1:0]     matchAttr;

  vpt_datapath #(.NUM_SLOTS(NUM_SLOTS), .VA_W(VA_W), .PA_W(PA_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .insVaddr   (insVaddr),
    .insSize    (insSize),
    .insPbase   (insPbase),
    .insAttr    (insAttr),
    .lkVaddr    (lkVaddr),
    .validVec   (validVec),
    .anyMatch   (anyMatch),
    .hitSlot    (hitSlot),
    .matchPaddr (matchPaddr),
    .matchAttr  (matchAttr)
  );

  vpt_lru_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .insValid (insValid),
    .lkValid  (lkValid),
    .lkTouch  (lkTouch),
    .pagingOn (pagingOn),
    .anyMatch (anyMatch),
    .hitSlot  (hitSlot),
    .validVec (validVec),
    .strobe   (strobe),
    .hitQ     (hitQ),
    .faultQ   (faultQ)
  );

  assign lkHit   = lkValid && pagingOn && anyMatch;
  assign lkPaddr = pagingOn ? matchPaddr : PA_W'(lkVaddr);
  assign lkAttr  = lkHit ? matchAttr : '0;

endmodule

// File: rtl/vpage_tlb_chk.sv
module vpage_tlb_chk #(
  parameter int NUM_SLOTS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 insValid,
  input logic                 lkValid,
  input logic                 pagingOn,
  input logic                 lkHit,
  input logic                 hitQ,
  input logic                 faultQ,
  input logic [NUM_SLOTS-1:0] validVec
);

  // R6
  hit_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lkHit |=> hitQ);

  // R6
  single_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hitQ && faultQ));

  // R5
  paging_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkValid && !pagingOn) |=> (!faultQ && !hitQ));

  // R7
  fill_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insValid && !(&validVec)) |=> ($countones(validVec) == $past($countones(validVec)) + 1));

  // R7
  fill_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (insValid && !validVec[0]) |=> validVec[0]);

  // R8
  full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&validVec) |=> (&validVec));

endmodule

bind vpage_tlb vpage_tlb_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .insValid (insValid),
  .lkValid  (lkValid),
  .pagingOn (pagingOn),
  .lkHit    (lkHit),
  .hitQ     (hitQ),
  .faultQ   (faultQ),
  .validVec (validVec)
);

// File: tb/vpage_tlb_test.sv
`timescale 1ns/1ps
module vpage_tlb_test;
  localparam int N   = 4;
  localparam int VAW = 32;
  localparam int PAW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           insValid = 1'b0;
  logic [VAW-1:0] insVaddr = '0;
  logic [1:0]     insSize  = '0;
  logic [PAW-1:0] insPbase = '0;
  logic [5:0]     insAttr  = '0;
  logic           lkValid  = 1'b0;
  logic [VAW-1:0] lkVaddr  = '0;
  logic           lkTouch  = 1'b0;
  logic           pagingOn = 1'b1;
  logic           lkHit;
  logic [PAW-1:0] lkPaddr;
  logic [5:0]     lkAttr;
  logic           hitQ;
  logic           faultQ;

  vpage_tlb #(.NUM_SLOTS(N), .VA_W(VAW), .PA_W(PAW)) uut (
    .clk(clk), .rst_n(rst_n),
    .insValid(insValid), .insVaddr(insVaddr), .insSize(insSize),
    .insPbase(insPbase), .insAttr(insAttr),
    .lkValid(lkValid), .lkVaddr(lkVaddr), .lkTouch(lkTouch), .pagingOn(pagingOn),
    .lkHit(lkHit), .lkPaddr(lkPaddr), .lkAttr(lkAttr), .hitQ(hitQ), .faultQ(faultQ)
  );

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  // Reference model state
  bit             mv [N];
  logic [VAW-1:0] mb [N];
  logic [1:0]     ms [N];
  logic [PAW-1:0] mp [N];
  logic [5:0]     ma [N];
  int             mr [N];

  function automatic int shOf(input logic [1:0] s);
    case (s)
      2'd1:    return 21;
      2'd2:    return 22;
      default: return 12;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic promote(input int idx);
    int r;
    r = mr[idx];
    for (int j = 0; j < N; j++) if (mr[j] < r) mr[j]++;
    mr[idx] = 0;
  endtask

  task automatic step(input bit ins, input logic [VAW-1:0] iva, input logic [1:0] isz,
                      input logic [PAW-1:0] ipb, input logic [5:0] iat,
                      input bit lk, input logic [VAW-1:0] lva, input bit tch, input bit pg,
                      input string tag);
    bit mh;
    int mi;
    int v;
    logic [VAW:0]   lim;
    logic [PAW-1:0] ep;
    bit eh;
    bit ef;
    @(negedge clk);
    insValid = ins; insVaddr = iva; insSize = isz; insPbase = ipb; insAttr = iat;
    lkValid = lk; lkVaddr = lva; lkTouch = tch; pagingOn = pg;
    #1;
    mh = 1'b0; mi = 0;
    for (int i = 0; i < N; i++) begin
      lim = {1'b0, mb[i]} + ((VAW+1)'(1) << shOf(ms[i]));
      if (!mh && mv[i] && mb[i] <= lva && {1'b0, lva} < lim) begin
        mh = 1'b1; mi = i;
      end
    end
    eh = lk && pg && mh;
    ef = lk && pg && !mh;
    chk(lkHit === eh, tag, "lkHit", 64'(lkHit), 64'(eh));
    if (eh) begin
      ep = mp[mi] | PAW'(lva & ((VAW'(1) << shOf(ms[mi])) - VAW'(1)));
      chk(lkPaddr === ep, "R4", "lkPaddr", 64'(lkPaddr), 64'(ep));
      chk(lkAttr === ma[mi], "R4", "lkAttr", 64'(lkAttr), 64'(ma[mi]));
    end
    if (lk && !pg) begin
      chk(lkPaddr === PAW'(lva), "R5", "lkPaddr passthrough", 64'(lkPaddr), 64'(lva));
      chk(lkAttr === 6'd0, "R5", "lkAttr passthrough", 64'(lkAttr), 64'd0);
    end
    // model update: insert aging first, then touch
    if (ins) begin
      v = -1;
      for (int i = 0; i < N; i++) if (v < 0 && !mv[i]) v = i;
      if (v < 0) for (int i = 0; i < N; i++) if (mr[i] == N - 1) v = i;
      mv[v] = 1'b1;
      ms[v] = isz;
      mb[v] = iva & ~((VAW'(1) << shOf(isz)) - VAW'(1));
      mp[v] = ipb & ~((PAW'(1) << shOf(isz)) - PAW'(1));
      ma[v] = iat;
      promote(v);
    end
    if (eh && tch) promote(mi);
    @(posedge clk);
    #1;
    chk(hitQ === eh, "R6", "hitQ", 64'(hitQ), 64'(eh));
    chk(faultQ === ef, "R6", "faultQ", 64'(faultQ), 64'(ef));
  endtask

  task automatic ins4k(input logic [VAW-1:0] va, input logic [PAW-1:0] pa,
                       input logic [5:0] at, input string tag);
    step(1'b1, va, 2'd0, pa, at, 1'b0, '0, 1'b0, 1'b1, tag);
  endtask

  task automatic look(input logic [VAW-1:0] va, input bit tch, input string tag);
    step(1'b0, '0, 2'd0, '0, '0, 1'b1, va, tch, 1'b1, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [VAW-1:0] rva;
    int j;
    int sh;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < N; i++) begin
      mv[i] = 1'b0; mb[i] = '0; ms[i] = '0; mp[i] = '0; ma[i] = '0; mr[i] = i;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    #1;
    chk(hitQ === 1'b0, "R1", "hitQ after reset", 64'(hitQ), 64'd0);
    chk(faultQ === 1'b0, "R1", "faultQ after reset", 64'(faultQ), 64'd0);
    look(32'h0001_0000, 1'b0, "R1");

    // R7 fill lowest free slots with 4 KB pages
    for (int k = 0; k < N; k++)
      ins4k(32'h0001_0123 + 32'(k) * 32'h0001_0000, 36'hA_0000_0000 + 36'(k) * 36'h1000,
            6'(k + 1), "R7");
    for (int k = 0; k < N; k++)
      look(32'h0001_0FFF + 32'(k) * 32'h0001_0000, 1'b0, "R7");

    // R9 touch the oldest, then R8 eviction hits the next oldest
    look(32'h0001_0000, 1'b1, "R9");
    ins4k(32'h0005_0000, 36'hB_0000_0000, 6'h3F, "R8");
    look(32'h0002_0000, 1'b0, "R8");
    look(32'h0001_0000, 1'b0, "R8");
    // R9 untouched lookup does not save the oldest entry
    look(32'h0003_0000, 1'b0, "R9");
    ins4k(32'h0006_0000, 36'hB_0000_1000, 6'h15, "R9");
    look(32'h0003_0000, 1'b0, "R9");
    look(32'h0006_0000, 1'b0, "R8");

    // R3 / R2 page-size alignment and boundaries
    step(1'b1, 32'h00A3_4567, 2'd1, 36'hC_1234_5678, 6'h21, 1'b0, '0, 1'b0, 1'b1, "R3");
    look(32'h00A0_0000, 1'b0, "R2");
    look(32'h00BF_FFFF, 1'b0, "R2");
    look(32'h00C0_0000, 1'b0, "R2");
    look(32'h009F_FFFF, 1'b0, "R2");
    step(1'b1, 32'h00C1_2345, 2'd2, 36'hD_0765_4321, 6'h0A, 1'b0, '0, 1'b0, 1'b1, "R3");
    look(32'h00FF_FFFF, 1'b0, "R2");
    look(32'h0100_0000, 1'b0, "R2");
    look(32'h00C0_0000, 1'b0, "R2");
    step(1'b1, 32'h0200_0ABC, 2'd3, 36'hE_0000_0FFF, 6'h11, 1'b0, '0, 1'b0, 1'b1, "R3");
    look(32'h0200_0FFF, 1'b0, "R2");
    look(32'h0200_1000, 1'b0, "R2");

    // R4 overlap: 4 MB page covering the 2 MB page
    step(1'b1, 32'h0080_0000, 2'd2, 36'hF_0040_0000, 6'h2C, 1'b0, '0, 1'b0, 1'b1, "R4");
    look(32'h00A0_0010, 1'b0, "R4");
    look(32'h0080_0010, 1'b0, "R4");

    // R5 paging off, touch has no effect on age order
    step(1'b0, '0, 2'd0, '0, '0, 1'b1, 32'h00A0_0010, 1'b1, 1'b0, "R5");
    step(1'b0, '0, 2'd0, '0, '0, 1'b1, 32'h0777_7777, 1'b0, 1'b0, "R5");
    ins4k(32'h0300_0000, 36'h1_0000_0000, 6'h01, "R5");
    look(32'h00A0_0010, 1'b0, "R5");
    look(32'h0080_0010, 1'b0, "R5");

    // R10 insert and touching lookup in the same cycle
    step(1'b1, 32'h0400_0000, 2'd0, 36'h2_0000_0000, 6'h02, 1'b1, 32'h0300_0008, 1'b1, 1'b1, "R10");
    step(1'b1, 32'h0400_0000, 2'd0, 36'h2_0000_0000, 6'h03, 1'b1, 32'h0400_0004, 1'b1, 1'b1, "R10");
    ins4k(32'h0500_0000, 36'h3_0000_0000, 6'h04, "R10");
    ins4k(32'h0600_0000, 36'h4_0000_0000, 6'h05, "R10");
    look(32'h0300_0008, 1'b0, "R10");
    look(32'h0400_0004, 1'b0, "R10");

    // Random mix
    for (int t = 0; t < 4000; t++) begin
      if ($urandom % 2 == 0) begin
        j = int'($urandom % N);
        sh = shOf(ms[j]);
        rva = mb[j] + VAW'($urandom % ((32'd1 << sh) + 64)) - VAW'(32);
      end else begin
        rva = $urandom & 32'h03FF_FFFF;
      end
      step(($urandom % 4) == 0, $urandom & 32'h03FF_FFFF, 2'($urandom % 4),
           {4'($urandom), 32'($urandom)}, 6'($urandom),
           ($urandom % 8) != 0, rva, $urandom % 2 == 0, ($urandom % 10) != 0, "R2");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule